// File: doc/BRIEF.md
# Interleaved Structure Load De-interleaver

This unit takes a stream of 32-bit elements in which each structure of `n` members (pairs, colour triples, quads) is stored one after another. It sorts those elements into `n` vector registers of four 32-bit lanes each. Member `j` of every structure goes to register `j`, and structure `k` fills lane `k`. A normal load therefore takes four structures, which is `4*n` elements.

A replicate variant reads only `n` elements. It copies element `j` into all four lanes of register `j`. This gives a set of splatted operands for arithmetic against one value per register.

A load begins with a one-cycle start pulse that carries the member count and the mode. Elements then arrive on a valid/ready stream. A done pulse marks the cycle in which the final register contents are visible. Registers that the current load does not address keep their earlier contents.

Top module: `sld_deinterleave`

## Requirements
- R1: After reset, all four vector outputs are zero, `elemReady` is low and `donePulse` is low.
- R2: `elemReady` is low while no load is in progress. It is high from the cycle after an accepted start until the final element of the load is accepted.
- R3: In a normal load (`replicate`=0), exactly `4*n` elements are taken. The element with stream index `i` lands in register `i mod n`, lane `i div n`. Lane `k` occupies bits `[32k+31:32k]` of a register output.
- R4: In a replicate load (`replicate`=1), exactly `n` elements are taken, and element `j` is written to all four lanes of register `j`.
- R5: A register whose index is at or above `n` keeps its previous contents through the whole load.
- R6: `donePulse` is high for exactly one cycle: the cycle after the final element is accepted. In that cycle `elemReady` is already low and the outputs hold the completed result.
- R7: A start pulse whose `memberCount` (the binary value of `n`) lies outside 2 to 4 is ignored. The unit stays idle and no register changes.
- R8: A start pulse that arrives while a load is in progress is ignored. The running load completes with its original count and mode.
- R9: A cycle with `elemValid` low during a load consumes nothing. The registers and the element position hold, and `elemReady` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a load when idle |
| memberCount | input | 3 | Members per structure `n` (valid 2..4) |
| replicate | input | 1 | 1 selects the broadcast variant |
| elemValid | input | 1 | Element on `elemData` is valid |
| elemData | input | 32 | Stream element |
| elemReady | output | 1 | Unit accepts an element this cycle |
| vecOut0 | output | 128 | Vector register 0 |
| vecOut1 | output | 128 | Vector register 1 |
| vecOut2 | output | 128 | Vector register 2 |
| vecOut3 | output | 128 | Vector register 3 |
| donePulse | output | 1 | One-cycle completion strobe |

## Verification
An accepted start raises `elemReady` one edge later. Each accepted element updates its register at that same edge. `donePulse` and the fall of `elemReady` follow one edge after the final accept.

The bench drives every input on the falling clock edge and samples on the next falling edge. Every value it reads is therefore exactly one rising edge older than the stimulus, with no count that needs adjusting. Gap cycles, illegal counts and a start pulse during a load are observed through the outputs at the same half-cycle offset.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int NREG        = 4;
  localparam int LANES       = 4;
  localparam int SEL_W       = $clog2(NREG);
  localparam int LANE_SEL_W  = $clog2(LANES);
  localparam int CNT_W       = $clog2(NREG + 1);
  localparam int MIN_MEMBERS = 2;

  typedef struct packed {
    logic                  wrEn;
    logic                  bcast;
    logic [SEL_W-1:0]      regSel;
    logic [LANE_SEL_W-1:0] laneSel;
  } sldStrobe_t;
endpackage

// File: rtl/sld_ctrl.sv
module sld_ctrl
  import sld_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] memberCount,
  input  logic             replicate,
  input  logic             elemValid,
  output logic             busy,
  output logic             donePulse,
  output sldStrobe_t       strobe
);
  logic [CNT_W-1:0]      nReg;
  logic                  repMode;
  logic [SEL_W-1:0]      memberIdx;
  logic [LANE_SEL_W-1:0] laneIdx;
  logic                  countOk;
  logic                  memberLast;
  logic                  loadLast;

  assign countOk    = (memberCount >= CNT_W'(MIN_MEMBERS)) && (memberCount <= CNT_W'(NREG));
  assign memberLast = (CNT_W'(memberIdx) == nReg - CNT_W'(1));
  assign loadLast   = memberLast && (repMode || (laneIdx == LANE_SEL_W'(LANES - 1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      donePulse <= 1'b0;
      nReg      <= '0;
      repMode   <= 1'b0;
      memberIdx <= '0;
      laneIdx   <= '0;
    end else begin
      donePulse <= 1'b0;
      if (!busy) begin
        if (startPulse && countOk) begin
          busy      <= 1'b1;
          nReg      <= memberCount;
          repMode   <= replicate;
          memberIdx <= '0;
          laneIdx   <= '0;
        end
      end else if (elemValid) begin
        if (loadLast) begin
          busy      <= 1'b0;
          donePulse <= 1'b1;
        end else if (memberLast) begin
          memberIdx <= '0;
          laneIdx   <= laneIdx + LANE_SEL_W'(1);
        end else begin
          memberIdx <= memberIdx + SEL_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn    = busy && elemValid;
    strobe.bcast   = repMode;
    strobe.regSel  = memberIdx;
    strobe.laneSel = laneIdx;
  end
endmodule

// File: rtl/sld_datapath.sv
module sld_datapath
  import sld_pkg::*;
#(
  parameter int ELEM_W = 32,
  localparam int REG_W = ELEM_W * LANES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sldStrobe_t                 strobe,
  input  logic [ELEM_W-1:0]          elemData,
  output logic [NREG-1:0][REG_W-1:0] vecRegs
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = strobe.wrEn && (strobe.regSel == SEL_W'(r)) &&
                   (strobe.bcast || (strobe.laneSel == LANE_SEL_W'(l)));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          vecRegs[r][l*ELEM_W +: ELEM_W] <= '0;
        end else if (hit) begin
          vecRegs[r][l*ELEM_W +: ELEM_W] <= elemData;
        end
      end
    end
  end
endmodule

// File: rtl/sld_deinterleave.sv
module sld_deinterleave
  import sld_pkg::*;
#(
  parameter int ELEM_W = 32,
  localparam int REG_W = ELEM_W * LANES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] memberCount,
  input  logic             replicate,
  input  logic             elemValid,
  input  logic [ELEM_W-1:0] elemData,
  output logic             elemReady,
  output logic [REG_W-1:0] vecOut0,
  output logic [REG_W-1:0] vecOut1,
  output logic [REG_W-1:0] vecOut2,
  output logic [REG_W-1:0] vecOut3,
  output logic             donePulse
);
  sldStrobe_t                 strobe;
  logic [NREG-1:0][REG_W-1:0] vecRegs;

  sld_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .memberCount (memberCount),
    .replicate   (replicate),
    .elemValid   (elemValid),
    .busy        (elemReady),
    .donePulse   (donePulse),
    .strobe      (strobe)
  );

  sld_datapath #(.ELEM_W(ELEM_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .elemData (elemData),
    .vecRegs  (vecRegs)
  );

  assign vecOut0 = vecRegs[0];
  assign vecOut1 = vecRegs[1];
  assign vecOut2 = vecRegs[2];
  assign vecOut3 = vecRegs[3];
endmodule

// File: rtl/sld_checker.sv
module sld_checker
  import sld_pkg::*;
#(
  parameter int REG_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [CNT_W-1:0] memberCount,
  input logic             elemValid,
  input logic             elemReady,
  input logic             donePulse,
  input logic [REG_W-1:0] vecOut0,
  input logic [REG_W-1:0] vecOut1,
  input logic [REG_W-1:0] vecOut2,
  input logic [REG_W-1:0] vecOut3
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r6_ready_low_at_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !elemReady);

  a_r2_idle_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!elemReady && !startPulse) |=> !elemReady);

  a_r7_bad_count_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!elemReady && startPulse && ((memberCount < 3'd2) || (memberCount > 3'd4))) |=> !elemReady);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (elemReady && !elemValid) |=> (elemReady && $stable(vecOut0) && $stable(vecOut1) &&
                                   $stable(vecOut2) && $stable(vecOut3)));

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !elemReady |=> ($stable(vecOut0) && $stable(vecOut1) && $stable(vecOut2) && $stable(vecOut3)));
endmodule

bind sld_deinterleave sld_checker #(.REG_W(REG_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .memberCount (memberCount),
  .elemValid   (elemValid),
  .elemReady   (elemReady),
  .donePulse   (donePulse),
  .vecOut0     (vecOut0),
  .vecOut1     (vecOut1),
  .vecOut2     (vecOut2),
  .vecOut3     (vecOut3)
);

// File: tb/sld_deinterleave_tb_top.sv
`timescale 1ns/1ps
module sld_deinterleave_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startPulse = 1'b0;
  logic [2:0]   memberCount = 3'd0;
  logic         replicate = 1'b0;
  logic         elemValid = 1'b0;
  logic [31:0]  elemData = '0;
  logic         elemReady;
  logic [127:0] vecOut0, vecOut1, vecOut2, vecOut3;
  logic         donePulse;

  int checks = 0;
  int failures = 0;
  logic [127:0] expReg [4];

  always #2 clk = ~clk;

  sld_deinterleave dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .memberCount(memberCount),
    .replicate(replicate), .elemValid(elemValid), .elemData(elemData),
    .elemReady(elemReady), .vecOut0(vecOut0), .vecOut1(vecOut1),
    .vecOut2(vecOut2), .vecOut3(vecOut3), .donePulse(donePulse)
  );

  // {gaps, replicate, n}
  localparam logic [4:0] CASES [8] = '{
    5'b0_0_010, 5'b0_0_011, 5'b0_0_100, 5'b1_0_011,
    5'b0_1_100, 5'b0_1_010, 5'b1_1_011, 5'b0_0_010
  };

  function automatic logic [127:0] vecAt(input int r);
    case (r)
      0: return vecOut0;
      1: return vecOut1;
      2: return vecOut2;
      default: return vecOut3;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkRegs(input int n, input string tagIn, input string tagOut);
    for (int r = 0; r < 4; r++) begin
      chk((r < n) ? tagIn : tagOut, vecAt(r), expReg[r]);
    end
  endtask

  task automatic runLoad(input int n, input bit rep, input bit gaps,
                         input logic [7:0] seed, input int injectAt);
    int total;
    total = rep ? n : 4 * n;
    @(negedge clk);
    startPulse = 1'b1; memberCount = 3'(n); replicate = rep;
    @(negedge clk);
    startPulse = 1'b0; memberCount = 3'd0; replicate = 1'b0;
    for (int i = 0; i < total; i++) begin
      logic [31:0] d;
      d = {seed, 16'h5a00, 8'(i)};
      chk("R2 ready during load", 128'(elemReady), 128'(1));
      if (gaps && (i % 2 == 1)) begin
        elemValid = 1'b0;
        @(negedge clk);
        chk("R9 ready held in gap", 128'(elemReady), 128'(1));
        chk("R9 no done in gap", 128'(donePulse), 128'(0));
        chkRegs(n, "R9 regs held in gap", "R9 regs held in gap");
      end
      elemValid = 1'b1; elemData = d;
      if (i == injectAt) begin
        startPulse = 1'b1; memberCount = 3'd4; replicate = 1'b1;
      end
      if (rep) begin
        expReg[i] = {4{d}};
      end else begin
        expReg[i % n][(i / n) * 32 +: 32] = d;
      end
      @(negedge clk);
      startPulse = 1'b0; memberCount = 3'd0; replicate = 1'b0;
      if (i < total - 1) chk("R6 no early done", 128'(donePulse), 128'(0));
    end
    elemValid = 1'b0;
    chk("R6 done after last", 128'(donePulse), 128'(1));
    chk("R6 ready low at done", 128'(elemReady), 128'(0));
    chkRegs(n, rep ? "R4 replicate result" : "R3 normal result", "R5 upper regs kept");
    @(negedge clk);
    chk("R6 done one cycle", 128'(donePulse), 128'(0));
    chk("R2 ready low idle", 128'(elemReady), 128'(0));
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) expReg[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 128'(elemReady), 128'(0));
    chk("R1 reset done", 128'(donePulse), 128'(0));
    chkRegs(4, "R1 reset regs", "R1 reset regs");

    for (int c = 0; c < 8; c++) begin
      runLoad(int'(CASES[c][2:0]), CASES[c][3], CASES[c][4], 8'(8'hA0 + c), -1);
    end

    // R7: illegal counts are ignored
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      startPulse = 1'b1;
      memberCount = (b == 0) ? 3'd1 : ((b == 1) ? 3'd5 : 3'd0);
      @(negedge clk);
      startPulse = 1'b0; memberCount = 3'd0;
      elemValid = 1'b1; elemData = 32'hdeadbeef;
      chk("R7 bad count stays idle", 128'(elemReady), 128'(0));
      @(negedge clk);
      elemValid = 1'b0;
      chk("R7 no done", 128'(donePulse), 128'(0));
      chkRegs(4, "R7 regs unchanged", "R7 regs unchanged");
    end

    // R8: start during a load is ignored
    runLoad(2, 1'b0, 1'b0, 8'hC8, 2);
    runLoad(3, 1'b1, 1'b0, 8'hC9, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule